// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer, used to make waveforms. It watches a counter value supplied on a port and compares it against a programmable compare value. From that comparison it drives an active-high internal reference signal. Two registered pins are derived from the reference: a main output and a complementary output. Each pin has its own polarity bit.

A single configuration write strobe loads every field at once:
- the 3-bit compare behaviour code;
- shadow enable, which holds new compare values in a preload register until an update pulse arrives;
- fast enable, which takes the match one clock earlier;
- external-clear enable;
- the two polarity bits;
- the channel enable;
- the 2-bit direction field.

When external clear is enabled, a high level on the clear input forces the reference low. The direction field is locked while the channel is enabled. Only direction 00 (output) lets the reference run. Every configuration field takes effect on the clock edge of its write.

Top module: `oc_channel`

## Requirements
- R1: After a synchronous reset, ref_o is 0, dir_o is 00, and out_o and out_n_o are both 0 (all configuration bits reset to 0).
- R2: Mode code 000 (frozen) keeps ref_o at its present value whatever the counter does.
- R3: Mode 001 sets ref_o to 1 on a match (counter equals active compare value). Mode 010 clears ref_o to 0 on a match. Mode 011 inverts ref_o on each matching cycle. Without a match these modes hold ref_o.
- R4: Mode 100 forces ref_o to 0 and mode 101 forces ref_o to 1, regardless of the counter.
- R5: Mode 110 makes ref_o 1 while counter < compare and 0 otherwise. Mode 111 gives the inverse.
- R6: With clear enable set, a high ext_clr_i makes ref_o 0 on the next edge, overriding every mode. With clear enable 0, ext_clr_i has no effect.
- R7: With fast enable 0, a counter value presented before edge N changes ref_o after edge N+1. With fast enable 1, it changes ref_o after edge N.
- R8: With shadow enable 0, a compare write becomes active on its edge. With shadow enable 1, the write goes to a preload register and update_i copies it into the active value. When a write and update_i share an edge, the active value takes the older preload content.
- R9: The direction field is loaded by a configuration write only if the channel enable was 0 before that edge. When enable is 0 or dir_o is nonzero, ref_o becomes 0.
- R10: When the channel is active, out_o = ref_o XOR pol and out_n_o = (NOT ref_o) XOR npol. When it is inactive, out_o = pol and out_n_o = npol. Both pins update on the same edge as ref_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Running timer counter value |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | CNT_W | Compare value to write |
| update_i | input | 1 | Update event pulse (preload to active) |
| ext_clr_i | input | 1 | External clear level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Compare behaviour code |
| cfg_shadow_i | input | 1 | Shadow (preload) enable |
| cfg_fast_i | input | 1 | Fast match enable |
| cfg_clren_i | input | 1 | External clear enable |
| cfg_pol_i | input | 1 | Main output polarity (1 = active low) |
| cfg_npol_i | input | 1 | Complementary output polarity (1 = active low) |
| cfg_en_i | input | 1 | Channel enable |
| cfg_dir_i | input | 2 | Direction select (00 = output) |
| ref_o | output | 1 | Internal reference, active high |
| out_o | output | 1 | Main output pin level |
| out_n_o | output | 1 | Complementary output pin level |
| dir_o | output | 2 | Direction field currently held |

## Verification
Two functions can land on the same edge: an external clear, and a match that would raise the reference.

The bench provokes this collision in set-on-match mode. It holds the counter at the compare value and raises ext_clr_i in the same cycle, then expects the reference low, because the clear must win. It repeats the collision under forced-high mode.

A second collision is a shadowed compare write arriving on the same edge as an update pulse. That case is judged by which compare value later produces a match.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN = 3'd0,
    OC_SET    = 3'd1,
    OC_CLR    = 3'd2,
    OC_TOG    = 3'd3,
    OC_LOW    = 3'd4,
    OC_HIGH   = 3'd5,
    OC_PWM1   = 3'd6,
    OC_PWM2   = 3'd7
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e    mode;
    logic        shadow;
    logic        fast;
    logic        clren;
    logic        pol;
    logic        npol;
    logic        en;
    logic [1:0]  dir;
  } oc_cfg_t;

  localparam logic [1:0] DIR_OUT = 2'b00;

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
  import oc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  oc_cfg_t wr,
  output oc_cfg_t cfg
);

  oc_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.mode   <= wr.mode;
      cfg_q.shadow <= wr.shadow;
      cfg_q.fast   <= wr.fast;
      cfg_q.clren  <= wr.clren;
      cfg_q.pol    <= wr.pol;
      cfg_q.npol   <= wr.npol;
      cfg_q.en     <= wr.en;
      // direction is locked while the channel is enabled
      if (!cfg_q.en) cfg_q.dir <= wr.dir;
    end
  end

  assign cfg = cfg_q;

  p_dir_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (we && cfg_q.en) |=> $stable(cfg_q.dir));

endmodule

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] data,
  input  logic             shadow,
  input  logic             update,
  output logic [CNT_W-1:0] active
);

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (we) pre_q <= data;
      if (we && !shadow)         act_q <= data;
      else if (shadow && update) act_q <= pre_q;
    end
  end

  assign active = act_q;

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (shadow && !update) |=> $stable(act_q));

endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             fast,
  output logic             hit,
  output logic             below
);

  logic hit_c, below_c;
  logic hit_q, below_q;

  assign hit_c   = (cnt == cmp);
  assign below_c = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      below_q <= 1'b0;
    end else begin
      hit_q   <= hit_c;
      below_q <= below_c;
    end
  end

  assign hit   = fast ? hit_c   : hit_q;
  assign below = fast ? below_c : below_q;

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  oc_cfg_t cfg,
  input  logic    hit,
  input  logic    below,
  input  logic    ext_clr,
  output logic    ref_o,
  output logic    out_o,
  output logic    out_n_o
);

  logic active, clear, ref_d;
  logic ref_q, out_q, outn_q;

  assign active = cfg.en && (cfg.dir == DIR_OUT);
  assign clear  = cfg.clren && ext_clr;

  always_comb begin
    ref_d = ref_q;
    unique case (cfg.mode)
      OC_FROZEN: ref_d = ref_q;
      OC_SET:    if (hit) ref_d = 1'b1;
      OC_CLR:    if (hit) ref_d = 1'b0;
      OC_TOG:    if (hit) ref_d = ~ref_q;
      OC_LOW:    ref_d = 1'b0;
      OC_HIGH:   ref_d = 1'b1;
      OC_PWM1:   ref_d = below;
      OC_PWM2:   ref_d = ~below;
      default:   ref_d = ref_q;
    endcase
    if (clear || !active) ref_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      out_q  <= 1'b0;
      outn_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      out_q  <= ref_d ^ cfg.pol;
      outn_q <= active ? (~ref_d ^ cfg.npol) : cfg.npol;
    end
  end

  assign ref_o   = ref_q;
  assign out_o   = out_q;
  assign out_n_o = outn_q;

  p_ext_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !ref_q);

  p_inactive_low_r9: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ref_q);

  p_force_high_r4: assert property (@(posedge clk) disable iff (rst)
    (active && cfg.mode == OC_HIGH && !clear) |=> ref_q);

  p_set_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (active && cfg.mode == OC_SET && hit && !clear) |=> ref_q);

  p_main_pol_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_q == (ref_q ^ $past(cfg.pol))));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             update_i,
  input  logic             ext_clr_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_shadow_i,
  input  logic             cfg_fast_i,
  input  logic             cfg_clren_i,
  input  logic             cfg_pol_i,
  input  logic             cfg_npol_i,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_dir_i,
  output logic             ref_o,
  output logic             out_o,
  output logic             out_n_o,
  output logic [1:0]       dir_o
);

  oc_cfg_t          wr_cfg;
  oc_cfg_t          cfg;
  logic [CNT_W-1:0] cmp_act;
  logic             hit, below;

  always_comb begin
    wr_cfg.mode   = oc_mode_e'(cfg_mode_i);
    wr_cfg.shadow = cfg_shadow_i;
    wr_cfg.fast   = cfg_fast_i;
    wr_cfg.clren  = cfg_clren_i;
    wr_cfg.pol    = cfg_pol_i;
    wr_cfg.npol   = cfg_npol_i;
    wr_cfg.en     = cfg_en_i;
    wr_cfg.dir    = cfg_dir_i;
  end

  oc_cfg_regs u_cfg (
    .clk (clk),
    .rst (rst),
    .we  (cfg_we_i),
    .wr  (wr_cfg),
    .cfg (cfg)
  );

  oc_cmp_store #(.CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .we     (cmp_we_i),
    .data   (cmp_data_i),
    .shadow (cfg.shadow),
    .update (update_i),
    .active (cmp_act)
  );

  oc_match #(.CNT_W(CNT_W)) u_match (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_i),
    .cmp   (cmp_act),
    .fast  (cfg.fast),
    .hit   (hit),
    .below (below)
  );

  oc_ref_gen u_ref (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .hit     (hit),
    .below   (below),
    .ext_clr (ext_clr_i),
    .ref_o   (ref_o),
    .out_o   (out_o),
    .out_n_o (out_n_o)
  );

  assign dir_o = cfg.dir;

endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt = '0;
  logic             cmp_we = 1'b0;
  logic [CNT_W-1:0] cmp_data = '0;
  logic             update = 1'b0;
  logic             ext_clr = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       c_mode = '0;
  logic             c_shadow = 1'b0, c_fast = 1'b0, c_clren = 1'b0;
  logic             c_pol = 1'b0, c_npol = 1'b0, c_en = 1'b0;
  logic [1:0]       c_dir = '0;
  logic             ref_o, out_o, out_n_o;
  logic [1:0]       dir_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  oc_channel #(.CNT_W(CNT_W)) i_oc_channel (
    .clk(clk), .rst(rst), .cnt_i(cnt), .cmp_we_i(cmp_we), .cmp_data_i(cmp_data),
    .update_i(update), .ext_clr_i(ext_clr), .cfg_we_i(cfg_we),
    .cfg_mode_i(c_mode), .cfg_shadow_i(c_shadow), .cfg_fast_i(c_fast),
    .cfg_clren_i(c_clren), .cfg_pol_i(c_pol), .cfg_npol_i(c_npol),
    .cfg_en_i(c_en), .cfg_dir_i(c_dir),
    .ref_o(ref_o), .out_o(out_o), .out_n_o(out_n_o), .dir_o(dir_o)
  );

  // vector: {mode[2:0], cnt[15:0], clr, expected ref}; compare = 8, fast on
  localparam logic [20:0] VEC [0:11] = '{
    {3'd5, 16'd0, 1'b0, 1'b1},   // R4 force high
    {3'd0, 16'd8, 1'b0, 1'b1},   // R2 frozen holds through match
    {3'd2, 16'd8, 1'b0, 1'b0},   // R3 clear on match
    {3'd1, 16'd3, 1'b0, 1'b0},   // R3 no match holds
    {3'd1, 16'd8, 1'b0, 1'b1},   // R3 set on match
    {3'd1, 16'd8, 1'b1, 1'b0},   // R6 clear beats set on match
    {3'd4, 16'd0, 1'b0, 1'b0},   // R4 force low
    {3'd6, 16'd7, 1'b0, 1'b1},   // R5 pwm1 below
    {3'd6, 16'd8, 1'b0, 1'b0},   // R5 pwm1 equal
    {3'd7, 16'd7, 1'b0, 1'b0},   // R5 pwm2 below
    {3'd7, 16'd9, 1'b0, 1'b1},   // R5 pwm2 above
    {3'd5, 16'd0, 1'b1, 1'b0}    // R6 clear beats force high
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] m, logic sh, logic fa, logic ce,
                           logic p, logic np, logic e, logic [1:0] d);
    c_mode = m; c_shadow = sh; c_fast = fa; c_clren = ce;
    c_pol = p; c_npol = np; c_en = e; c_dir = d;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cmp_write(logic [15:0] v, logic upd);
    cmp_data = v; cmp_we = 1'b1; update = upd;
    step();
    cmp_we = 1'b0; update = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 ref", ref_o, 0);
    check("R1 out", out_o, 0);
    check("R1 outn", out_n_o, 0);
    check("R1 dir", dir_o, 0);

    // vector table walk: compare 8, fast, clear enabled
    cfg_write(3'd5, 0, 1, 1, 0, 0, 1, 2'b00);
    cmp_write(16'd8, 1'b0);
    for (int i = 0; i < 12; i++) begin
      cnt = VEC[i][17:2];
      ext_clr = VEC[i][1];
      cfg_write(VEC[i][20:18], 0, 1, 1, 0, 0, 1, 2'b00);
      step();
      check($sformatf("R2-5 vec%0d ref", i), ref_o, VEC[i][0]);
      check($sformatf("R10 vec%0d out", i), out_o, VEC[i][0]);
      check($sformatf("R10 vec%0d outn", i), out_n_o, !VEC[i][0]);
    end
    ext_clr = 1'b0;

    // R7 normal latency: two edges
    cnt = 0;
    cfg_write(3'd4, 0, 0, 1, 0, 0, 1, 2'b00);
    cmp_write(16'd20, 1'b0);
    cfg_write(3'd1, 0, 0, 1, 0, 0, 1, 2'b00);
    step();
    cnt = 20;
    step();
    check("R7 normal after one edge", ref_o, 0);
    step();
    check("R7 normal after two edges", ref_o, 1);

    // R7 fast latency + R3 toggle
    cnt = 0;
    cfg_write(3'd4, 0, 1, 1, 0, 0, 1, 2'b00);
    step();
    cfg_write(3'd3, 0, 1, 1, 0, 0, 1, 2'b00);
    cnt = 20; step();
    check("R7 fast one edge / R3 toggle up", ref_o, 1);
    cnt = 0; step();
    check("R3 toggle holds off match", ref_o, 1);
    cnt = 20; step();
    check("R3 toggle down", ref_o, 0);

    // R8 shadow: preload held until update
    cnt = 50;
    cfg_write(3'd4, 1, 1, 1, 0, 0, 1, 2'b00);
    cmp_write(16'd50, 1'b0);
    cfg_write(3'd1, 1, 1, 1, 0, 0, 1, 2'b00);
    step();
    check("R8 preload not active", ref_o, 0);
    update = 1'b1; step(); update = 1'b0;
    step();
    check("R8 update makes active", ref_o, 1);

    // R8 immediate write without shadow
    cnt = 0;
    cfg_write(3'd4, 0, 1, 1, 0, 0, 1, 2'b00);
    cfg_write(3'd1, 0, 1, 1, 0, 0, 1, 2'b00);
    cmp_write(16'd60, 1'b0);
    cnt = 60; step();
    check("R8 immediate write", ref_o, 1);

    // R8 write and update on same edge: older preload wins
    cnt = 0;
    cfg_write(3'd4, 1, 1, 1, 0, 0, 1, 2'b00);
    cmp_write(16'd70, 1'b0);
    cmp_write(16'd80, 1'b1);
    cfg_write(3'd1, 1, 1, 1, 0, 0, 1, 2'b00);
    cnt = 80; step();
    check("R8 same edge new value not active", ref_o, 0);
    cnt = 70; step();
    check("R8 same edge old preload active", ref_o, 1);

    // R6 clear ignored when clear enable is 0
    cnt = 0; ext_clr = 1'b1;
    cfg_write(3'd5, 0, 1, 0, 0, 0, 1, 2'b00);
    step();
    check("R6 clear disabled", ref_o, 1);
    ext_clr = 1'b0;

    // R9 direction lock
    cfg_write(3'd5, 0, 1, 0, 0, 0, 1, 2'b10);
    check("R9 dir locked while enabled", dir_o, 0);
    cfg_write(3'd5, 0, 1, 0, 0, 0, 0, 2'b10);
    check("R9 dir locked on disabling write", dir_o, 0);
    cfg_write(3'd5, 0, 1, 0, 0, 0, 0, 2'b10);
    check("R9 dir written when disabled", dir_o, 2);
    cfg_write(3'd5, 0, 1, 0, 0, 0, 1, 2'b10);
    step();
    check("R9 input direction ref low", ref_o, 0);
    check("R10 input direction out inactive", out_o, 0);
    cfg_write(3'd5, 0, 1, 0, 0, 0, 0, 2'b00);

    // R10 polarity
    cfg_write(3'd5, 0, 1, 0, 1, 1, 1, 2'b00);
    step();
    check("R10 pol main active low", out_o, 0);
    check("R10 pol comp", out_n_o, 1);
    cfg_write(3'd5, 0, 1, 0, 1, 1, 0, 2'b00);
    step();
    check("R9 disabled ref low", ref_o, 0);
    check("R10 disabled main idle", out_o, 1);
    check("R10 disabled comp idle", out_n_o, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule